// File: doc/BRIEF.md
# Dual-Thread Power State Coordinator

This block follows the idle level of each of two hardware threads that share one core, and reduces the pair to a single core/package power state. A thread asks for a lighter or deeper idle level with a request strobe. The request gives a level code and a flag. The flag says whether the request came from a decoded read of a power-level register or from a wait-style instruction hint. The thread's level falls back to running when a wake event arrives. It also falls back when an armed monitor event reaches a thread that is waiting by hint.

The package level is always the shallower of the two thread levels. It therefore leaves the normal state only when both threads share a low-power level. Three outputs are derived from the package level. A one-cycle Stop-Grant acknowledge request is raised only while the stop-clock input is high. A deep-sleep request goes to the clock and voltage controller. An enhanced deep-sleep request depends on two configuration enables. A thread in C2 that receives a snoop leaves C2 for a fixed number of cycles, services the snoop in a snoopable sub-state, and then returns to C2. Per-thread outputs report wake-ups and snoop service.

Top module: `pwr_state_coord`

## Requirements
- R1: After reset both threads are running (C0). The package state is 0 (normal), and the Stop-Grant, deep-sleep, enhanced deep-sleep, wake and snoop-busy outputs are all 0.
- R2: The package state output is registered. It equals the shallower of the two thread levels as they stood one cycle earlier. The mapping is C0 or C1 to 0 (normal), C2 or the snoop sub-state to 1 (C2), and C4 to 2 (C4). If either thread is at C0 or C1, the state is 0.
- R3: A request is taken only while its thread is at C0. Level code 2'b10 moves the thread to C2 and 2'b11 moves it to C4, whatever the hint flag says. Level code 2'b00, and any request made while the thread is not at C0, leaves the thread where it is. Thread t uses bits [2t+1:2t] of the level input.
- R4: Level code 2'b01 with the hint flag at 0 is a register-read halt, and it always enters C1. With the hint flag at 1 it is a wait-based C1. A wait-based C1 is taken only if the other thread was already out of C0 in the previous cycle. Otherwise it is ignored and the thread stays at C0.
- R5: A monitor event returns a thread from wait-based C1 to C0. It has no effect on a thread that is in halt-based C1, or at any other level.
- R6: A wake input moves its thread to C0 on the next clock edge from any level, and it overrides a request in the same cycle. A thread's wake output pulses high for one cycle in the same cycle that its level changes from anything other than C0 to C0.
- R7: A snoop to a thread at C2 puts that thread in the snoop sub-state for SNOOP_CYCLES cycles (default 2), with its snoop-busy output high. The thread then returns to C2, and the package state stays at C2 throughout. A snoop to a thread at C0, C1 or C4 has no effect.
- R8: The Stop-Grant output is high for exactly one cycle in each residency at package state 1 or 2. It rises in the first cycle of that residency in which the stop-clock input is high, and it is never high while the stop-clock input is low. A move from C2 to C4 starts no new residency.
- R9: The deep-sleep output is high exactly while the package state is 2. The enhanced deep-sleep output is high exactly when deep-sleep is high and both the cache-sizing enable and the enhanced deep-sleep enable are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 2 | Per-thread idle request strobe |
| req_hint | input | 2 | Per-thread source flag: 1 = wait hint, 0 = register read |
| req_lvl | input | 4 | Per-thread level code (2 bits each): 01 C1, 10 C2, 11 C4 |
| wake | input | 2 | Per-thread interrupt or wake event |
| mon_evt | input | 2 | Per-thread armed monitor event |
| snoop | input | 2 | Per-thread snoop request, from the bus or the other thread |
| stpclk | input | 1 | Stop-clock pin level |
| cfg_dcs_en | input | 1 | Cache-sizing enable |
| cfg_edsl_en | input | 1 | Enhanced deep-sleep enable |
| pkg_state | output | 2 | Resolved package state: 0 normal, 1 C2, 2 C4 |
| sga_pulse | output | 1 | Stop-Grant acknowledge request pulse |
| deep_req | output | 1 | Deep-sleep request |
| deep_enh_req | output | 1 | Enhanced deep-sleep request |
| thr_wake | output | 2 | Per-thread wake indication pulse |
| thr_snoop_busy | output | 2 | Per-thread snoop sub-state indication |

## Verification
A thread stuck at the wrong level shows up at the ports within two cycles. The package state, and the deep-sleep outputs with it, takes the wrong value one edge after the level is registered. A missing or extra wake pulse appears on the very next edge. Halt-based C1 and wait-based C1 look the same at the package state, so the bench tells them apart by following a monitor event or a wake with a check on the wake output. A wrong Stop-Grant sent flag shows as a missing or repeated pulse within the same package residency. A miscounted snoop window shows as a snoop-busy output that is too long or too short.

// File: rtl/pwr_coord_pkg.sv
package pwr_coord_pkg;

   typedef enum logic [2:0] {
      TS_C0  = 3'd0,
      TS_C1  = 3'd1,
      TS_C2  = 3'd2,
      TS_SNP = 3'd3,
      TS_C4  = 3'd4
   } thr_st_e;

   typedef enum logic [1:0] {
      PK_NORM = 2'd0,
      PK_C2   = 2'd1,
      PK_C4   = 2'd2
   } pkg_st_e;

   localparam int unsigned LVL_W = 2;
   localparam logic [LVL_W-1:0] LVL_C1 = 2'b01;
   localparam logic [LVL_W-1:0] LVL_C2 = 2'b10;
   localparam logic [LVL_W-1:0] LVL_C4 = 2'b11;

   function automatic pkg_st_e rank_of(input thr_st_e s);
      case (s)
         TS_C2, TS_SNP: rank_of = PK_C2;
         TS_C4:         rank_of = PK_C4;
         default:       rank_of = PK_NORM;
      endcase
   endfunction

   function automatic pkg_st_e shallower(input pkg_st_e a, input pkg_st_e b);
      shallower = (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/pwr_thr_trk.sv
module pwr_thr_trk
   import pwr_coord_pkg::*;
#(
   parameter int unsigned SNOOP_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_vld_i,
   input  logic             req_hint_i,
   input  logic [LVL_W-1:0] req_lvl_i,
   input  logic             wake_i,
   input  logic             mon_evt_i,
   input  logic             snoop_i,
   input  thr_st_e          peer_st_i,
   output thr_st_e          st_o,
   output logic             wake_pulse_o,
   output logic             snp_act_o
);

   localparam int unsigned CNT_W = (SNOOP_CYCLES > 1) ? $clog2(SNOOP_CYCLES) : 1;

   thr_st_e st_q, st_d;
   logic    mwait_q, mwait_d;
   logic    wk_q;
   logic    snp_done;

   // snoop window length variant
   generate
      if (SNOOP_CYCLES == 1) begin : g_snp_single
         assign snp_done = 1'b1;
      end else begin : g_snp_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (st_q == TS_SNP) begin
               cnt_q <= cnt_q + 1'b1;
            end else begin
               cnt_q <= '0;
            end
         end
         assign snp_done = (cnt_q == CNT_W'(SNOOP_CYCLES - 1));
      end
   endgenerate

   always_comb begin
      st_d    = st_q;
      mwait_d = mwait_q;
      if (wake_i) begin
         st_d    = TS_C0;
         mwait_d = 1'b0;
      end else begin
         case (st_q)
            TS_C0: begin
               if (req_vld_i) begin
                  case (req_lvl_i)
                     LVL_C1: begin
                        if (!req_hint_i) begin
                           st_d    = TS_C1;
                           mwait_d = 1'b0;
                        end else if (peer_st_i != TS_C0) begin
                           st_d    = TS_C1;
                           mwait_d = 1'b1;
                        end
                     end
                     LVL_C2:  st_d = TS_C2;
                     LVL_C4:  st_d = TS_C4;
                     default: st_d = TS_C0;
                  endcase
               end
            end
            TS_C1: begin
               if (mon_evt_i && mwait_q) begin
                  st_d    = TS_C0;
                  mwait_d = 1'b0;
               end
            end
            TS_C2: begin
               if (snoop_i) st_d = TS_SNP;
            end
            TS_SNP: begin
               if (snp_done) st_d = TS_C2;
            end
            default: st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= TS_C0;
         mwait_q <= 1'b0;
         wk_q    <= 1'b0;
      end else begin
         st_q    <= st_d;
         mwait_q <= mwait_d;
         wk_q    <= (st_q != TS_C0) && (st_d == TS_C0);
      end
   end

   assign st_o         = st_q;
   assign wake_pulse_o = wk_q;
   assign snp_act_o    = (st_q == TS_SNP);

endmodule

// File: rtl/pwr_pkg_res.sv
module pwr_pkg_res
   import pwr_coord_pkg::*;
#(
   parameter int unsigned NUM_THR = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  thr_st_e st_i [NUM_THR],
   input  logic    cfg_dcs_en_i,
   input  logic    cfg_edsl_en_i,
   output pkg_st_e pkg_o,
   output logic    deep_o,
   output logic    deep_enh_o
);

   pkg_st_e acc;
   pkg_st_e pkg_q;

   always_comb begin
      acc = PK_C4;
      for (int i = 0; i < NUM_THR; i++) begin
         acc = shallower(acc, rank_of(st_i[i]));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkg_q <= PK_NORM;
      end else begin
         pkg_q <= acc;
      end
   end

   assign pkg_o      = pkg_q;
   assign deep_o     = (pkg_q == PK_C4);
   assign deep_enh_o = deep_o && cfg_dcs_en_i && cfg_edsl_en_i;

endmodule

// File: rtl/pwr_sga_gen.sv
module pwr_sga_gen
   import pwr_coord_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  pkg_st_e pkg_i,
   input  logic    stpclk_i,
   output logic    sga_o
);

   logic in_low;
   logic sent_q;

   assign in_low = (pkg_i != PK_NORM);
   assign sga_o  = in_low && stpclk_i && !sent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sent_q <= 1'b0;
      end else if (in_low) begin
         sent_q <= sent_q | sga_o;
      end else begin
         sent_q <= 1'b0;
      end
   end

endmodule

// File: rtl/pwr_state_coord.sv
module pwr_state_coord
   import pwr_coord_pkg::*;
#(
   parameter int unsigned NUM_THR      = 2,
   parameter int unsigned SNOOP_CYCLES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_THR-1:0]       req_vld,
   input  logic [NUM_THR-1:0]       req_hint,
   input  logic [NUM_THR*LVL_W-1:0] req_lvl,
   input  logic [NUM_THR-1:0]       wake,
   input  logic [NUM_THR-1:0]       mon_evt,
   input  logic [NUM_THR-1:0]       snoop,
   input  logic                     stpclk,
   input  logic                     cfg_dcs_en,
   input  logic                     cfg_edsl_en,
   output logic [1:0]               pkg_state,
   output logic                     sga_pulse,
   output logic                     deep_req,
   output logic                     deep_enh_req,
   output logic [NUM_THR-1:0]       thr_wake,
   output logic [NUM_THR-1:0]       thr_snoop_busy
);

   generate
      if (NUM_THR != 2) begin : g_bad_thr
         $error("pwr_state_coord: NUM_THR must be 2");
      end
      if (SNOOP_CYCLES < 1) begin : g_bad_snp
         $error("pwr_state_coord: SNOOP_CYCLES must be at least 1");
      end
   endgenerate

   thr_st_e thr_st [NUM_THR];
   pkg_st_e pkg_w;

   generate
      for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
         pwr_thr_trk #(
            .SNOOP_CYCLES (SNOOP_CYCLES)
         ) u_trk (
            .clk          (clk),
            .rst_n        (rst_n),
            .req_vld_i    (req_vld[i]),
            .req_hint_i   (req_hint[i]),
            .req_lvl_i    (req_lvl[i*LVL_W +: LVL_W]),
            .wake_i       (wake[i]),
            .mon_evt_i    (mon_evt[i]),
            .snoop_i      (snoop[i]),
            .peer_st_i    (thr_st[(i + 1) % NUM_THR]),
            .st_o         (thr_st[i]),
            .wake_pulse_o (thr_wake[i]),
            .snp_act_o    (thr_snoop_busy[i])
         );
      end
   endgenerate

   pwr_pkg_res #(
      .NUM_THR (NUM_THR)
   ) u_res (
      .clk           (clk),
      .rst_n         (rst_n),
      .st_i          (thr_st),
      .cfg_dcs_en_i  (cfg_dcs_en),
      .cfg_edsl_en_i (cfg_edsl_en),
      .pkg_o         (pkg_w),
      .deep_o        (deep_req),
      .deep_enh_o    (deep_enh_req)
   );

   pwr_sga_gen u_sga (
      .clk      (clk),
      .rst_n    (rst_n),
      .pkg_i    (pkg_w),
      .stpclk_i (stpclk),
      .sga_o    (sga_pulse)
   );

   assign pkg_state = pkg_w;

endmodule

// File: rtl/pwr_coord_chk.sv
module pwr_coord_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] wake,
   input logic [1:0] snoop,
   input logic       stpclk,
   input logic       cfg_dcs_en,
   input logic       cfg_edsl_en,
   input logic [1:0] pkg_state,
   input logic       sga_pulse,
   input logic       deep_req,
   input logic       deep_enh_req,
   input logic [1:0] thr_wake,
   input logic [1:0] thr_snoop_busy,
   input logic [2:0] st_a,
   input logic [2:0] st_b
);

   // thread level codes: 0 C0, 1 C1, 2 C2, 3 snoop, 4 C4
   a_r6_wake_a: assert property (@(posedge clk) disable iff (!rst_n)
      wake[0] |=> (st_a == 3'd0));

   a_r6_wake_b: assert property (@(posedge clk) disable iff (!rst_n)
      wake[1] |=> (st_b == 3'd0));

   a_r6_pulse_running: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wake[0] |-> (st_a == 3'd0));

   a_r2_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_a <= 3'd1) || (st_b <= 3'd1)) |=> (pkg_state == 2'd0));

   a_r2_both_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_a >= 3'd2) && (st_b >= 3'd2)) |=> (pkg_state != 2'd0));

   a_r9_deep_c4: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_a == 3'd4) && (st_b == 3'd4)) |=> deep_req);

   a_r9_enh_gate: assert property (@(posedge clk) disable iff (!rst_n)
      deep_enh_req |-> (deep_req && cfg_dcs_en && cfg_edsl_en));

   a_r8_stpclk_gate: assert property (@(posedge clk) disable iff (!rst_n)
      sga_pulse |-> (stpclk && (pkg_state != 2'd0)));

   a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
      sga_pulse |=> !sga_pulse);

   a_r7_snoop_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thr_snoop_busy[0]) |-> $past(snoop[0]));

   a_r7_snoop_cause_b: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thr_snoop_busy[1]) |-> $past(snoop[1]));

endmodule

bind pwr_state_coord pwr_coord_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wake           (wake),
   .snoop          (snoop),
   .stpclk         (stpclk),
   .cfg_dcs_en     (cfg_dcs_en),
   .cfg_edsl_en    (cfg_edsl_en),
   .pkg_state      (pkg_state),
   .sga_pulse      (sga_pulse),
   .deep_req       (deep_req),
   .deep_enh_req   (deep_enh_req),
   .thr_wake       (thr_wake),
   .thr_snoop_busy (thr_snoop_busy),
   .st_a           (thr_st[0]),
   .st_b           (thr_st[1])
);

// File: tb/sim_pwr_state_coord.sv
module sim_pwr_state_coord;

   localparam int CLK_PERIOD = 10;
   localparam int SNPC       = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] req_vld = '0, req_hint = '0, wake = '0, mon_evt = '0, snoop = '0;
   logic [3:0] req_lvl = '0;
   logic       stpclk = 1'b0, cfg_dcs_en = 1'b0, cfg_edsl_en = 1'b0;
   logic [1:0] pkg_state, thr_wake, thr_snoop_busy;
   logic       sga_pulse, deep_req, deep_enh_req;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model: 0 C0, 1 C1, 2 C2, 3 snoop, 4 C4
   int ms[2], mf[2], mc[2], mw[2];
   int mpk = 0;
   int msent = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_state_coord #(.NUM_THR(2), .SNOOP_CYCLES(SNPC)) u0 (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_hint(req_hint),
      .req_lvl(req_lvl), .wake(wake), .mon_evt(mon_evt), .snoop(snoop),
      .stpclk(stpclk), .cfg_dcs_en(cfg_dcs_en), .cfg_edsl_en(cfg_edsl_en),
      .pkg_state(pkg_state), .sga_pulse(sga_pulse), .deep_req(deep_req),
      .deep_enh_req(deep_enh_req), .thr_wake(thr_wake),
      .thr_snoop_busy(thr_snoop_busy)
   );

   function automatic int rk(input int s);
      if (s <= 1) return 0;
      if (s == 4) return 2;
      return 1;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model_step();
      int ns[2];
      int nf[2];
      int nc[2];
      int pkn;
      int sg;
      for (int t = 0; t < 2; t++) begin
         int lvl;
         lvl = int'(req_lvl[2*t +: 2]);
         ns[t] = ms[t];
         nf[t] = mf[t];
         nc[t] = (ms[t] == 3) ? mc[t] + 1 : 0;
         if (wake[t]) begin
            ns[t] = 0; nf[t] = 0;
         end else if (ms[t] == 0) begin
            if (req_vld[t]) begin
               if (lvl == 1) begin
                  if (!req_hint[t]) begin ns[t] = 1; nf[t] = 0; end
                  else if (ms[1-t] != 0) begin ns[t] = 1; nf[t] = 1; end
               end else if (lvl == 2) ns[t] = 2;
               else if (lvl == 3) ns[t] = 4;
            end
         end else if (ms[t] == 1) begin
            if (mon_evt[t] && mf[t] == 1) begin ns[t] = 0; nf[t] = 0; end
         end else if (ms[t] == 2) begin
            if (snoop[t]) ns[t] = 3;
         end else if (ms[t] == 3) begin
            if (mc[t] == SNPC - 1) ns[t] = 2;
         end
      end
      pkn = (rk(ms[0]) < rk(ms[1])) ? rk(ms[0]) : rk(ms[1]);
      sg = (mpk != 0 && stpclk && msent == 0) ? 1 : 0;
      msent = (mpk != 0) ? ((msent != 0 || sg != 0) ? 1 : 0) : 0;
      mpk = pkn;
      for (int t = 0; t < 2; t++) begin
         mw[t] = (ms[t] != 0 && ns[t] == 0) ? 1 : 0;
         ms[t] = ns[t]; mf[t] = nf[t]; mc[t] = nc[t];
      end
   endtask

   task automatic check_outputs(input string tg);
      string tp;
      string tw;
      int e_deep;
      int e_sga;
      tp = (tg == "") ? "R2" : tg;
      tw = (tg == "") ? "R6" : tg;
      e_deep = (mpk == 2) ? 1 : 0;
      e_sga = (mpk != 0 && stpclk && msent == 0) ? 1 : 0;
      chk(tp, "pkg_state", int'(pkg_state), mpk);
      chk("R8", "sga_pulse", int'(sga_pulse), e_sga);
      chk("R9", "deep_req", int'(deep_req), e_deep);
      chk("R9", "deep_enh_req", int'(deep_enh_req), e_deep & int'(cfg_dcs_en) & int'(cfg_edsl_en));
      chk(tw, "thr_wake", int'(thr_wake), mw[1]*2 + mw[0]);
      chk("R7", "thr_snoop_busy", int'(thr_snoop_busy),
          ((ms[1] == 3) ? 2 : 0) + ((ms[0] == 3) ? 1 : 0));
   endtask

   task automatic cyc(input logic [1:0] v, input logic [1:0] h, input logic [3:0] l,
                      input logic [1:0] w, input logic [1:0] m, input logic [1:0] s,
                      input logic stp, input string tg);
      req_vld = v; req_hint = h; req_lvl = l; wake = w; mon_evt = m; snoop = s;
      stpclk = stp;
      model_step();
      @(negedge clk);
      check_outputs(tg);
   endtask

   task automatic idle(input int n, input logic stp, input string tg);
      for (int i = 0; i < n; i++) cyc(2'b00, 2'b00, 4'h0, 2'b00, 2'b00, 2'b00, stp, tg);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL R1 watchdog: actual=timeout expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int t = 0; t < 2; t++) begin ms[t] = 0; mf[t] = 0; mc[t] = 0; mw[t] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_outputs("R1");
      chk("R1", "deep_req", int'(deep_req), 0);

      // R3: register-read entries, requests outside C0 ignored
      cyc(2'b11, 2'b00, {2'b11, 2'b11}, 2'b00, 2'b00, 2'b00, 1'b0, "R3");
      idle(2, 1'b0, "R3");
      cyc(2'b01, 2'b01, {2'b00, 2'b10}, 2'b00, 2'b00, 2'b00, 1'b0, "R3");
      idle(2, 1'b0, "R3");
      cyc(2'b00, 2'b00, 4'h0, 2'b11, 2'b00, 2'b00, 1'b0, "R6");
      cyc(2'b11, 2'b11, {2'b11, 2'b00}, 2'b00, 2'b00, 2'b00, 1'b0, "R3");
      idle(2, 1'b0, "R3");
      cyc(2'b00, 2'b00, 4'h0, 2'b11, 2'b00, 2'b00, 1'b0, "R6");
      idle(1, 1'b0, "");

      // R4: wait C1 gated by the other thread; R5: monitor only wakes wait C1
      cyc(2'b01, 2'b01, {2'b00, 2'b01}, 2'b00, 2'b00, 2'b00, 1'b0, "R4");
      cyc(2'b00, 2'b00, 4'h0, 2'b01, 2'b00, 2'b00, 1'b0, "R4");
      cyc(2'b10, 2'b00, {2'b01, 2'b00}, 2'b00, 2'b00, 2'b00, 1'b0, "R4");
      cyc(2'b01, 2'b01, {2'b00, 2'b01}, 2'b00, 2'b00, 2'b00, 1'b0, "R4");
      cyc(2'b00, 2'b00, 4'h0, 2'b00, 2'b10, 2'b00, 1'b0, "R5");
      cyc(2'b00, 2'b00, 4'h0, 2'b00, 2'b01, 2'b00, 1'b0, "R5");
      cyc(2'b00, 2'b00, 4'h0, 2'b10, 2'b00, 2'b00, 1'b0, "R6");
      idle(1, 1'b0, "");

      // R7: snoop round trip in C2, ignored in C4 and C0
      cyc(2'b11, 2'b00, {2'b10, 2'b10}, 2'b00, 2'b00, 2'b00, 1'b0, "R7");
      idle(2, 1'b0, "R7");
      cyc(2'b00, 2'b00, 4'h0, 2'b00, 2'b00, 2'b01, 1'b0, "R7");
      idle(4, 1'b0, "R7");
      cyc(2'b00, 2'b00, 4'h0, 2'b11, 2'b00, 2'b00, 1'b0, "R6");
      cyc(2'b00, 2'b00, 4'h0, 2'b00, 2'b00, 2'b11, 1'b0, "R7");
      cyc(2'b11, 2'b00, {2'b11, 2'b11}, 2'b00, 2'b00, 2'b00, 1'b0, "R7");
      idle(2, 1'b0, "R7");
      cyc(2'b00, 2'b00, 4'h0, 2'b00, 2'b00, 2'b11, 1'b0, "R7");
      idle(2, 1'b0, "R7");

      // R9: enable combinations while in C4
      for (int c = 0; c < 4; c++) begin
         cfg_dcs_en = c[0]; cfg_edsl_en = c[1];
         idle(1, 1'b0, "R9");
      end
      cyc(2'b00, 2'b00, 4'h0, 2'b11, 2'b00, 2'b00, 1'b0, "R6");
      idle(1, 1'b0, "R9");

      // R8: stop-grant once per residency, gated by stop-clock
      cyc(2'b11, 2'b00, {2'b10, 2'b10}, 2'b00, 2'b00, 2'b00, 1'b0, "R8");
      idle(2, 1'b0, "R8");
      idle(3, 1'b1, "R8");
      idle(1, 1'b0, "R8");
      idle(2, 1'b1, "R8");
      cyc(2'b00, 2'b00, 4'h0, 2'b01, 2'b00, 2'b00, 1'b1, "R6");
      idle(2, 1'b1, "R8");
      cyc(2'b01, 2'b00, {2'b00, 2'b11}, 2'b00, 2'b00, 2'b00, 1'b1, "R8");
      idle(3, 1'b1, "R8");
      cyc(2'b00, 2'b00, 4'h0, 2'b11, 2'b00, 2'b00, 1'b1, "R6");
      idle(2, 1'b0, "");

      // sweep every level pair and hint combination
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            for (int h = 0; h < 4; h++) begin
               cfg_dcs_en = h[0]; cfg_edsl_en = h[1] ^ a[0];
               cyc(2'b11, h[1:0], {b[1:0], a[1:0]}, 2'b00, 2'b00, 2'b00, 1'((a + b) % 2), "R3");
               idle(2, 1'b1, "");
               cyc(2'b11, 2'b11, {a[1:0], b[1:0]}, 2'b00, 2'b00, 2'b00, 1'b1, "R4");
               cyc(2'b00, 2'b00, 4'h0, 2'b00, 2'b11, 2'b11, 1'b1, "R5");
               idle(3, 1'b0, "");
               cyc(2'b00, 2'b00, 4'h0, 2'b11, 2'b00, 2'b00, 1'b0, "R6");
               idle(1, 1'b0, "");
            end
         end
      end

      // random traffic on both threads
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] v, h, w, m, s;
         logic [3:0] l;
         v = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
         h = 2'($urandom_range(0, 3));
         l = 4'($urandom_range(0, 15));
         w = {($urandom_range(0, 19) == 0), ($urandom_range(0, 19) == 0)};
         m = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
         s = {($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0)};
         if ($urandom_range(0, 31) == 0) begin
            cfg_dcs_en = 1'($urandom_range(0, 1));
            cfg_edsl_en = 1'($urandom_range(0, 1));
         end
         cyc(v, h, l, w, m, s, 1'($urandom_range(0, 1)), "");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule